// File: doc/BRIEF.md
# Banked Pin Controller with Shared Interrupt

This block drives and samples a set of general-purpose pins grouped into banks of up to 32 pins. For every pin, software chooses the direction, whether the pin drives in open-drain fashion, the output value, and the condition that raises an interrupt. The trigger can be a rising edge, a falling edge, either edge, or a high level. Pad inputs are resynchronised to the block clock before they are used. Detected events are held in a per-bank pending register that software clears by writing ones. Pending bits that are enabled in the per-bank enable register are merged into a single interrupt output shared by all banks.

Access is through a simple register port. A write is a one-cycle strobe with address and data. Read data is combinational from the address. Each bank occupies a 32-byte window that holds eight 32-bit words. The number of banks and the width of each bank are parameters.

Top module: `gpx_ctrl`

## Requirements
- R1: After reset, every enable and pending bit is 0, every valid direction bit is 1 (input), `irq` is low and no pad is driven (`pad_oe` all 0).
- R2: The byte address selects the bank with bits [ADDR_W-1:5] and the word with bits [4:2]: 0x00 open-drain, 0x04 data, 0x08 direction, 0x0C rise-select, 0x10 any-edge, 0x14 enable, 0x18 level, 0x1C pending. Address bits [1:0] are ignored. A write touches only the addressed bank and register.
- R3: A pin whose direction bit is 0 and whose open-drain bit is 0 drives `pad_oe`=1 and `pad_out` equal to its data bit. A pin whose direction bit is 1 is never driven.
- R4: A pin that is an output with its open-drain bit at 1 drives low (`pad_oe`=1, `pad_out`=0) when its data bit is 0, and releases the pad (`pad_oe`=0) when its data bit is 1.
- R5: Reading the data word returns the synchronised pad level for input pins and the written data bit for output pins.
- R6: With the level bit at 0 and the any-edge bit at 1, both rising and falling pad edges set the pending bit, whatever the rise-select bit holds.
- R7: With level and any-edge bits at 0, a rise-select bit of 1 makes only rising edges set the pending bit, and 0 makes only falling edges set it.
- R8: With the level bit at 1, the pending bit is set on every cycle while the synchronised pad is high. Once the pad is low, a clear leaves it at 0.
- R9: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Pending bits never clear any other way.
- R10: When an event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R11: `irq` is high exactly when some bank has a bit set in both its pending and enable registers. Events set pending bits even while they are disabled.
- R12: Register bits at or above a bank's width read as 0 and ignore writes. Pads at those positions are never driven and never flag events.
- R13: A pad edge shows in the pending register on the third rising clock edge after the pad changes: two synchroniser stages, then detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (6 by default) | Byte address of the register word |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pad_in | input | NUM_BANKS*32 | Raw pad levels, 32 positions per bank |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables |
| irq | output | 1 | Combined interrupt of all banks |

## Verification
The bench targets the trigger decode across all four modes. A design that ignored the any-edge override would miss the falling edge when rise-select is set. A design that swapped the rise and fall senses would flag the wrong edge. It also targets the race between a clearing write and a held level. A design that let the clear win would show a pending bit that drops while the level persists. Other checks look at the three-cycle detection latency, which a missing or extra synchroniser stage shifts by one cycle, and at the narrow second bank. A design that stored bits above a bank's width would read them back or drive those pads. Open-drain release and the data readback path are also covered. A wrong readback mux would return the latch for input pins.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   localparam int unsigned MAX_PINS = 32;
   localparam int unsigned WFIELD   = 6;

   // word select within a bank window (address bits [4:2])
   typedef enum logic [2:0] {
      RS_OPEN_DRAIN = 3'd0,
      RS_DATA       = 3'd1,
      RS_DIR        = 3'd2,
      RS_RISE_SEL   = 3'd3,
      RS_ANY_EDGE   = 3'd4,
      RS_ENABLE     = 3'd5,
      RS_LEVEL      = 3'd6,
      RS_PEND       = 3'd7
   } gpx_reg_e;

   function automatic logic [MAX_PINS-1:0] width_mask(input int unsigned w);
      logic [MAX_PINS-1:0] m;
      m = '0;
      for (int i = 0; i < int'(MAX_PINS); i++)
         if (i < int'(w)) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  stg[k] <= '0;
         else if (k == 0) stg[k] <= d;
         else         stg[k] <= stg[(k == 0) ? 0 : k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
   import gpx_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  gpx_reg_e            sel,
   input  logic [MAX_PINS-1:0] wr_data,
   output logic [MAX_PINS-1:0] rd_data,
   input  logic [MAX_PINS-1:0] pin_in,
   output logic [MAX_PINS-1:0] pad_out,
   output logic [MAX_PINS-1:0] pad_oe,
   output logic                irq_req,
   output logic [MAX_PINS-1:0] st_q,
   output logic [MAX_PINS-1:0] en_q,
   output logic [MAX_PINS-1:0] dir_q,
   output logic [MAX_PINS-1:0] od_q
);

   if (WIDTH < 1 || WIDTH > MAX_PINS) begin : g_bad_width
      $error("gpx_bank: WIDTH must lie in 1..32");
   end

   localparam logic [MAX_PINS-1:0] VMASK = width_mask(WIDTH);

   logic [MAX_PINS-1:0] dat_q, rise_q, any_q, lvl_q;
   logic [MAX_PINS-1:0] s_q, prev_q, evt, clr, wmask;

   assign wmask = wr_data & VMASK;

   // configuration words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         od_q   <= '0;
         dat_q  <= '0;
         dir_q  <= VMASK;
         rise_q <= '0;
         any_q  <= '0;
         en_q   <= '0;
         lvl_q  <= '0;
      end else if (wr_en) begin
         case (sel)
            RS_OPEN_DRAIN: od_q   <= wmask;
            RS_DATA:       dat_q  <= wmask;
            RS_DIR:        dir_q  <= wmask;
            RS_RISE_SEL:   rise_q <= wmask;
            RS_ANY_EDGE:   any_q  <= wmask;
            RS_ENABLE:     en_q   <= wmask;
            RS_LEVEL:      lvl_q  <= wmask;
            default:       ;
         endcase
      end
   end

   // input resynchronisation and history
   gpx_sync #(.W(MAX_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in & VMASK),
      .q     (s_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= s_q;
   end

   // trigger decode: level wins, then any-edge, then rise/fall select
   always_comb begin
      evt = VMASK & (  ( lvl_q &  s_q)
                     | (~lvl_q &  any_q & (s_q ^ prev_q))
                     | (~lvl_q & ~any_q &  rise_q &  s_q & ~prev_q)
                     | (~lvl_q & ~any_q & ~rise_q & ~s_q &  prev_q));
   end

   assign clr = (wr_en && sel == RS_PEND) ? wmask : '0;

   // pending: clear first, new events override the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= ((st_q & ~clr) | evt) & VMASK;
   end

   // pad drive: open-drain pins only ever pull low
   assign pad_oe  = VMASK & ~dir_q & ~(od_q & dat_q);
   assign pad_out = VMASK & dat_q & ~od_q;

   always_comb begin
      case (sel)
         RS_OPEN_DRAIN: rd_data = od_q;
         RS_DATA:       rd_data = (dir_q & s_q) | (~dir_q & dat_q);
         RS_DIR:        rd_data = dir_q;
         RS_RISE_SEL:   rd_data = rise_q;
         RS_ANY_EDGE:   rd_data = any_q;
         RS_ENABLE:     rd_data = en_q;
         RS_LEVEL:      rd_data = lvl_q;
         RS_PEND:       rd_data = st_q;
         default:       rd_data = '0;
      endcase
   end

   assign irq_req = |(st_q & en_q);

endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
   import gpx_pkg::*;
#(
   parameter int unsigned              NUM_BANKS   = 2,
   parameter logic [NUM_BANKS*6-1:0]   BANK_WIDTHS = {6'd12, 6'd32},
   parameter int unsigned              SYNC_STAGES = 2,
   localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned ADDR_W     = BANK_IDX_W + 5,
   localparam int unsigned NPINS      = NUM_BANKS * MAX_PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpx_ctrl: NUM_BANKS must be at least 1");
   end

   logic [BANK_IDX_W-1:0] bank_idx;
   gpx_reg_e              sel;
   logic                  unused_lo;

   assign bank_idx  = reg_addr[ADDR_W-1:5];
   assign sel       = gpx_reg_e'(reg_addr[4:2]);
   assign unused_lo = ^reg_addr[1:0];

   logic [MAX_PINS-1:0] bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] irq_vec;
   logic [NPINS-1:0]     st_all, en_all, dir_all, od_all;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned BW = int'(BANK_WIDTHS[b*WFIELD +: WFIELD]);

      gpx_bank #(.WIDTH(BW), .SYNC_STAGES(SYNC_STAGES)) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr && bank_idx == BANK_IDX_W'(b)),
         .sel     (sel),
         .wr_data (reg_wdata),
         .rd_data (bank_rd[b]),
         .pin_in  (pad_in [b*MAX_PINS +: MAX_PINS]),
         .pad_out (pad_out[b*MAX_PINS +: MAX_PINS]),
         .pad_oe  (pad_oe [b*MAX_PINS +: MAX_PINS]),
         .irq_req (irq_vec[b]),
         .st_q    (st_all [b*MAX_PINS +: MAX_PINS]),
         .en_q    (en_all [b*MAX_PINS +: MAX_PINS]),
         .dir_q   (dir_all[b*MAX_PINS +: MAX_PINS]),
         .od_q    (od_all [b*MAX_PINS +: MAX_PINS])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++)
         if (bank_idx == BANK_IDX_W'(b)) reg_rdata = bank_rd[b];
   end

   assign irq = |irq_vec;

endmodule

// File: rtl/gpx_chk.sv
module gpx_chk
   import gpx_pkg::*;
#(
   parameter int unsigned            NUM_BANKS   = 2,
   parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd12, 6'd32},
   parameter int unsigned            ADDR_W      = 6,
   localparam int unsigned           NPINS       = NUM_BANKS * MAX_PINS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              irq,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  st_all,
   input logic [NPINS-1:0]  en_all,
   input logic [NPINS-1:0]  dir_all,
   input logic [NPINS-1:0]  od_all
);

   function automatic logic [NPINS-1:0] valid_bits();
      logic [NPINS-1:0] v;
      v = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++)
         v[b*MAX_PINS +: MAX_PINS] = width_mask(int'(BANK_WIDTHS[b*WFIELD +: WFIELD]));
      return v;
   endfunction

   localparam logic [NPINS-1:0] VALID = valid_bits();

   // R3: an input pin is never driven
   a_r3_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & dir_all) == '0);

   // R4: an open-drain pin never drives high
   a_r4_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & od_all) == '0);

   // R9: a pending bit drops only after a write to a pending word
   a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(st_all) & ~st_all)) |-> ($past(reg_wr) && $past(reg_addr[4:2]) == 3'd7));

   // R11: nothing enabled means no interrupt
   a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_all == '0) |-> !irq);

   // R12: positions beyond a bank's width stay inert
   a_r12_unused_inert: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | st_all | en_all) & ~VALID) == '0);

endmodule

bind gpx_ctrl gpx_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .BANK_WIDTHS (BANK_WIDTHS),
   .ADDR_W      (ADDR_W)
) i_gpx_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_wr   (reg_wr),
   .irq      (irq),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .st_all   (st_all),
   .en_all   (en_all),
   .dir_all  (dir_all),
   .od_all   (od_all)
);

// File: tb/test_gpx_ctrl.sv
module test_gpx_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] pad_in = '0;
   logic [63:0] pad_out, pad_oe;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpx_ctrl i_gpx_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq       (irq)
   );

   // {is_read, byte address, write data or expected read data}
   localparam int NV = 20;
   localparam logic [40:0] VEC [NV] = '{
      {1'b1, 8'h08, 32'hFFFFFFFF},
      {1'b1, 8'h28, 32'h00000FFF},
      {1'b1, 8'h14, 32'h00000000},
      {1'b1, 8'h3C, 32'h00000000},
      {1'b0, 8'h34, 32'hFFFFFFFF},
      {1'b1, 8'h34, 32'h00000FFF},
      {1'b0, 8'h34, 32'h00000000},
      {1'b1, 8'h34, 32'h00000000},
      {1'b0, 8'h0C, 32'hA5A5A5A5},
      {1'b1, 8'h0E, 32'hA5A5A5A5},
      {1'b1, 8'h2C, 32'h00000000},
      {1'b0, 8'h0C, 32'h00000000},
      {1'b0, 8'h38, 32'h00012345},
      {1'b1, 8'h38, 32'h00000345},
      {1'b0, 8'h38, 32'h00000000},
      {1'b0, 8'h10, 32'h0F0F0000},
      {1'b1, 8'h10, 32'h0F0F0000},
      {1'b1, 8'h18, 32'h00000000},
      {1'b0, 8'h10, 32'h00000000},
      {1'b1, 8'h00, 32'h00000000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1: reset state at the ports
      chk("R1 irq after reset", {63'd0, irq}, 64'd0);
      chk("R1 pad_oe after reset", pad_oe, 64'd0);

      // table walk: R1 R2 R12 register map and width clipping
      for (int k = 0; k < NV; k++) begin
         if (VEC[k][40]) begin
            rd(VEC[k][37:32], v);
            chk($sformatf("R2/R12/R1 table row %0d", k), {32'd0, v}, {32'd0, VEC[k][31:0]});
         end else begin
            wr(VEC[k][37:32], VEC[k][31:0]);
         end
      end

      // R3 push-pull output, R5 readback of latch
      wr(6'h08, 32'hFFFFFFFE);
      wr(6'h04, 32'h1);
      chk("R3 oe pin0", {63'd0, pad_oe[0]}, 64'd1);
      chk("R3 out pin0 high", {63'd0, pad_out[0]}, 64'd1);
      rd(6'h04, v);
      chk("R5 output pin reads latch", {63'd0, v[0]}, 64'd1);
      wr(6'h04, 32'h0);
      chk("R3 out pin0 low", {pad_oe[0], pad_out[0]}, 64'd2);
      wr(6'h08, 32'hFFFFFFFF);
      chk("R3 input not driven", {63'd0, pad_oe[0]}, 64'd0);

      // R4 open drain
      wr(6'h00, 32'h2);
      wr(6'h08, 32'hFFFFFFFD);
      chk("R4 od pulls low", {pad_oe[1], pad_out[1]}, 64'd2);
      wr(6'h04, 32'h2);
      chk("R4 od releases", {pad_oe[1], pad_out[1]}, 64'd0);
      wr(6'h08, 32'hFFFFFFFF);
      wr(6'h00, 32'h0);

      // R5 input readback
      pad_in[2] = 1'b1;
      wait_cyc(3);
      rd(6'h04, v);
      chk("R5 input pin reads pad", {32'd0, v}, 64'h4);
      wr(6'h1C, 32'hFFFFFFFF);

      // R13 latency and R7 rising-only
      wr(6'h0C, 32'h8);
      reg_addr = 6'h1C;
      @(negedge clk);
      pad_in[3] = 1'b1;
      wait_cyc(2);
      #1;
      chk("R13 not yet after two edges", {63'd0, reg_rdata[3]}, 64'd0);
      wait_cyc(1);
      #1;
      chk("R13/R7 rising sets on third edge", {63'd0, reg_rdata[3]}, 64'd1);
      chk("R11 disabled pending gives no irq", {63'd0, irq}, 64'd0);
      wr(6'h14, 32'h8);
      chk("R11 enabled pending raises irq", {63'd0, irq}, 64'd1);
      wr(6'h1C, 32'h0);
      rd(6'h1C, v);
      chk("R9 writing zero keeps bit", {63'd0, v[3]}, 64'd1);
      wr(6'h1C, 32'h8);
      rd(6'h1C, v);
      chk("R9 writing one clears", {63'd0, v[3]}, 64'd0);
      chk("R11 irq drops after clear", {63'd0, irq}, 64'd0);
      pad_in[3] = 1'b0;
      wait_cyc(4);
      rd(6'h1C, v);
      chk("R7 rising mode ignores fall", {63'd0, v[3]}, 64'd0);

      // R7 falling-only
      wr(6'h0C, 32'h0);
      pad_in[3] = 1'b1;
      wait_cyc(4);
      rd(6'h1C, v);
      chk("R7 falling mode ignores rise", {63'd0, v[3]}, 64'd0);
      pad_in[3] = 1'b0;
      wait_cyc(4);
      rd(6'h1C, v);
      chk("R7 falling mode flags fall", {63'd0, v[3]}, 64'd1);
      wr(6'h1C, 32'h8);

      // R6 both edges, rise-select ignored
      wr(6'h10, 32'h8);
      wr(6'h0C, 32'h8);
      wr(6'h1C, 32'h8);
      pad_in[3] = 1'b1;
      wait_cyc(4);
      rd(6'h1C, v);
      chk("R6 any-edge flags rise", {63'd0, v[3]}, 64'd1);
      wr(6'h1C, 32'h8);
      pad_in[3] = 1'b0;
      wait_cyc(4);
      rd(6'h1C, v);
      chk("R6 any-edge flags fall", {63'd0, v[3]}, 64'd1);
      wr(6'h1C, 32'h8);
      wr(6'h14, 32'h0);
      wr(6'h10, 32'h0);
      wr(6'h0C, 32'h0);

      // R8 level-high on bank 1 pin 0, R10 event beats clear
      wr(6'h38, 32'h1);
      pad_in[32] = 1'b1;
      wait_cyc(4);
      rd(6'h3C, v);
      chk("R8 level sets pending", {32'd0, v}, 64'h1);
      wr(6'h3C, 32'h1);
      rd(6'h3C, v);
      chk("R10 held level survives clear", {32'd0, v}, 64'h1);
      wr(6'h34, 32'h1);
      chk("R11 irq from second bank", {63'd0, irq}, 64'd1);
      pad_in[32] = 1'b0;
      wait_cyc(4);
      rd(6'h3C, v);
      chk("R9 pending stays until cleared", {32'd0, v}, 64'h1);
      wr(6'h3C, 32'h1);
      rd(6'h3C, v);
      chk("R8 clear holds once level gone", {32'd0, v}, 64'h0);
      chk("R11 irq low after level clear", {63'd0, irq}, 64'd0);
      wr(6'h34, 32'h0);
      wr(6'h38, 32'h0);

      // R12 pads beyond narrow bank width
      wr(6'h28, 32'h0);
      chk("R12 narrow bank drives only its width", pad_oe, 64'h00000FFF_00000000);
      wr(6'h28, 32'hFFFFFFFF);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule